// File: doc/BRIEF.md
# Light Sensor Register Target on a Two-Wire Bus

This block is the serial target of an ambient-light sensor. It answers at one fixed 7-bit bus address, 7'b1000100. Through that address a host reaches eight byte-wide registers. Four of them hold configuration and can be written: command, control, and upper and lower thresholds. The other four return the 16-bit sensor reading and the 16-bit timer count, one byte at a time.

The block does not use the bus clock as a clock. It samples the SCL and SDA lines on the system clock, finds edges and start/stop conditions from those samples, and pulls SDA low through a pull-down enable. The upper two bits of the register-pointer byte are not address bits. They are write-only commands. When set, they send one-cycle pulses to the integration logic and to the interrupt logic.

The supported transfers are single-byte writes and single-byte reads. A write is sent as address+W, pointer, data. A read is sent as address+W, pointer, repeated start, address+R, one byte, then a master NAK. Before a 16-bit value is read, the block freezes its upper byte when the lower byte is read. Clock stretching, general call and 10-bit addressing are not handled.

Top module: `lux_i2c_regs`

## Requirements
- R1: A byte after a start whose upper seven bits equal 7'b1000100 is acknowledged (SDA pulled low for the ninth clock). Any other address is not acknowledged, and all further bytes are ignored until the next start.
- R2: After reset, the command register (pointer 0) is 0x00, control (pointer 1) is 0x00, upper threshold (pointer 2) is 0xFF and lower threshold (pointer 3) is 0x00. A data byte written at pointer 0..3 replaces that register and is acknowledged.
- R3: A data byte written at pointer 4..7 is acknowledged but changes no register.
- R4: The register index is bits 2:0 of the pointer byte. Bits 5:3 have no effect on which register is accessed.
- R5: A 1 in bit 7 of the pointer byte produces exactly one single-cycle pulse on `integ_sync_o` per pointer byte.
- R6: A 1 in bit 6 of the pointer byte produces exactly one single-cycle pulse on `int_clear_o` per pointer byte.
- R7: A read (pointer, repeated start, address with R/W bit 1) returns the indexed register MSB first. The block releases SDA for the master's acknowledge bit. Only one byte is returned per read address.
- R8: Reading pointer 4 returns sensor bits 7:0 and freezes sensor bits 15:8. A later read of pointer 5 returns the frozen byte. Pointers 6 and 7 do the same for the timer.
- R9: A start or a stop releases SDA by the next cycle. Configuration registers keep their values across transfers until they are overwritten.
- R10: Only one data byte is accepted per write. A second data byte in the same transfer is not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| sensor_val_i | input | 16 | Latest sensor conversion result |
| timer_val_i | input | 16 | Latest integration timer count |
| cmd_reg_o | output | 8 | Command register contents |
| ctl_reg_o | output | 8 | Control register contents |
| thr_hi_o | output | 8 | Upper threshold register contents |
| thr_lo_o | output | 8 | Lower threshold register contents |
| integ_sync_o | output | 1 | One-cycle integration sync command |
| int_clear_o | output | 1 | One-cycle interrupt clear command |

## Verification
The assertions assume that SCL stays at each level for several system clocks, longer than the synchronizer latency. They also assume that SDA changes only while SCL is low, except when forming a start or a stop. The bench master follows these rules by holding every bus phase for ten system clocks and changing data only in the middle of the low phase. Because of this, the block never sees a false start or stop in the middle of a byte.

// File: rtl/lux_i2c_pkg.sv
// Shared constants and the transfer-state type for the sensor register target.
// Assumes: nothing; pure declarations.
package lux_i2c_pkg;
    localparam logic [6:0] DEV_ADDR   = 7'b1000100;
    localparam int         BYTE_W     = 8;
    localparam int         IDX_W      = 3;
    localparam int         NUM_CFG    = 4;
    localparam int         BITCNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_MACK,
        ST_SKIP
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL/SDA into the clock domain and flags edges and bus conditions.
// Assumes: bus levels are stable for longer than STAGES+1 clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;
    logic              scl_prev, sda_prev;

    // Synchronizer chains plus one history stage, idle-high on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
            scl_prev <= scl_q;
            sda_prev <= sda_q;
        end
    end

    assign scl_q      = scl_sh[STAGES-1];
    assign sda_q      = sda_sh[STAGES-1];
    assign sda_o      = sda_q;
    assign scl_rise_o = scl_q & ~scl_prev;
    assign scl_fall_o = ~scl_q & scl_prev;
    assign start_o    = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_o     = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/i2c_target_fsm.sv
// Byte engine of the target: address match, pointer, one write or read byte.
// Assumes: edge/condition flags are single-cycle and mutually exclusive.
module i2c_target_fsm
    import lux_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_take,
    output logic              sync_pulse,
    output logic              clr_pulse
);
    tgt_state_t          state;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   txreg;
    logic                rw_bit;
    logic                byte_done;

    assign byte_done = scl_fall && (bit_cnt == BITCNT_W'(BYTE_W));
    // Read byte is fetched at the fall that ends the address acknowledge.
    assign rd_take   = (state == ST_ADDR_ACK) && scl_fall && rw_bit
                       && !bus_start && !bus_stop;
    assign wr_data   = shreg;

    // Transfer sequencing, shift registers and SDA pull control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
            rw_bit     <= 1'b0;
            sda_pull   <= 1'b0;
            reg_idx    <= '0;
            wr_en      <= 1'b0;
            sync_pulse <= 1'b0;
            clr_pulse  <= 1'b0;
        end else begin
            wr_en      <= 1'b0;
            sync_pulse <= 1'b0;
            clr_pulse  <= 1'b0;
            if (bus_start) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (bus_stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    sda_pull <= 1'b1;
                                    rw_bit   <= shreg[0];
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_PTR) begin
                                sda_pull   <= 1'b1;
                                reg_idx    <= shreg[IDX_W-1:0];
                                sync_pulse <= shreg[7];
                                clr_pulse  <= shreg[6];
                                state      <= ST_PTR_ACK;
                            end else begin
                                sda_pull <= 1'b1;
                                wr_en    <= 1'b1;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_bit) begin
                                txreg    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_SKIP;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            sda_pull <= 1'b0;
                            state    <= ST_MACK;
                        end else if (scl_fall) begin
                            sda_pull <= ~txreg[BYTE_W-2];
                            txreg    <= {txreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_MACK: begin
                        if (scl_fall) state <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lux_reg_file.sv
// Configuration registers, read multiplexer and upper-byte freeze on LSB reads.
// Assumes: wr_en and rd_take are single-cycle; reg_idx is stable around them.
module lux_reg_file
    import lux_i2c_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_take,
    input  logic [2*BYTE_W-1:0] sensor_val,
    input  logic [2*BYTE_W-1:0] timer_val,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [BYTE_W-1:0]   cfg_q [NUM_CFG]
);
    logic [BYTE_W-1:0] sens_hi_frz, tim_hi_frz;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [BYTE_W-1:0] RST_VAL = (g == 2) ? '1 : '0;
        logic [BYTE_W-1:0] q;
        // Holds one configuration byte until a write selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= RST_VAL;
            else if (wr_en && reg_idx == IDX_W'(g))    q <= wr_data;
        end
        assign cfg_q[g] = q;
    end

    // Freezes the upper data bytes when the matching lower byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sens_hi_frz <= '0;
            tim_hi_frz  <= '0;
        end else if (rd_take) begin
            if (reg_idx == 3'd4) sens_hi_frz <= sensor_val[2*BYTE_W-1:BYTE_W];
            if (reg_idx == 3'd6) tim_hi_frz  <= timer_val[2*BYTE_W-1:BYTE_W];
        end
    end

    // Selects the byte returned to the host.
    always_comb begin
        case (reg_idx)
            3'd4:    rd_data = sensor_val[BYTE_W-1:0];
            3'd5:    rd_data = sens_hi_frz;
            3'd6:    rd_data = timer_val[BYTE_W-1:0];
            3'd7:    rd_data = tim_hi_frz;
            default: rd_data = cfg_q[reg_idx[1:0]];
        endcase
    end
endmodule

// File: rtl/lux_i2c_regs.sv
// Top: two-wire target giving the host access to the light sensor registers.
// Assumes: open-drain pad outside; sda_i reflects the wired line level.
module lux_i2c_regs
    import lux_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull_o,
    input  logic [15:0] sensor_val_i,
    input  logic [15:0] timer_val_i,
    output logic [7:0]  cmd_reg_o,
    output logic [7:0]  ctl_reg_o,
    output logic [7:0]  thr_hi_o,
    output logic [7:0]  thr_lo_o,
    output logic        integ_sync_o,
    output logic        int_clear_o
);
    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [IDX_W-1:0]  reg_idx;
    logic              wr_en, rd_take;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic [BYTE_W-1:0] cfg_q [NUM_CFG];

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    i2c_target_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
        .rd_data(rd_data), .sda_pull(sda_pull_o), .reg_idx(reg_idx),
        .wr_en(wr_en), .wr_data(wr_data), .rd_take(rd_take),
        .sync_pulse(integ_sync_o), .clr_pulse(int_clear_o)
    );

    lux_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_take(rd_take), .sensor_val(sensor_val_i),
        .timer_val(timer_val_i), .rd_data(rd_data), .cfg_q(cfg_q)
    );

    assign cmd_reg_o = cfg_q[0];
    assign ctl_reg_o = cfg_q[1];
    assign thr_hi_o  = cfg_q[2];
    assign thr_lo_o  = cfg_q[3];
endmodule

// File: rtl/lux_i2c_regs_chk.sv
// Property checker for the sensor register target, bound to the top.
// Assumes: it observes the top's internal write enable and bus condition flags.
module lux_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull_o,
    input logic       integ_sync_o,
    input logic       int_clear_o,
    input logic [7:0] cmd_reg_o,
    input logic [7:0] ctl_reg_o,
    input logic [7:0] thr_hi_o,
    input logic [7:0] thr_lo_o,
    input logic       wr_en,
    input logic [2:0] reg_idx,
    input logic       bus_start,
    input logic       bus_stop
);
    a_r5_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        integ_sync_o |=> !integ_sync_o);
    a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        int_clear_o |=> !int_clear_o);
    a_r9_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cmd_reg_o) && $stable(ctl_reg_o)
                    && $stable(thr_hi_o) && $stable(thr_lo_o)));
    a_r3_readonly_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx[2]) |=> ($stable(cmd_reg_o) && $stable(ctl_reg_o)
                                   && $stable(thr_hi_o) && $stable(thr_lo_o)));
    a_r9_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !sda_pull_o);
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_pull_o);
endmodule

bind lux_i2c_regs lux_i2c_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o),
    .integ_sync_o(integ_sync_o), .int_clear_o(int_clear_o),
    .cmd_reg_o(cmd_reg_o), .ctl_reg_o(ctl_reg_o),
    .thr_hi_o(thr_hi_o), .thr_lo_o(thr_lo_o),
    .wr_en(wr_en), .reg_idx(reg_idx),
    .bus_start(bus_start), .bus_stop(bus_stop)
);

// File: tb/sim_lux_i2c_regs.sv
// Bench: a behavioural bus master plus a register model compared on every idle clock.
module sim_lux_i2c_regs;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [15:0] sensor_v = 16'h0000;
    logic [15:0] timer_v = 16'h0000;
    logic        sda_pull;
    logic [7:0]  cmd_q, ctl_q, hi_q, lo_q;
    logic        sync_p, clr_p;
    logic        sda_line;

    int checks = 0;
    int failures = 0;
    int n_sync = 0, n_clr = 0, e_sync = 0, e_clr = 0;
    bit busy = 1'b1;
    bit finished = 1'b0;
    logic [7:0] model [4];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    lux_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .sensor_val_i(sensor_v), .timer_val_i(timer_v),
        .cmd_reg_o(cmd_q), .ctl_reg_o(ctl_q), .thr_hi_o(hi_q), .thr_lo_o(lo_q),
        .integ_sync_o(sync_p), .int_clear_o(clr_p)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register model compared every idle clock (R2, R3, R9, R10).
    always @(negedge clk) begin
        if (rst_n && !busy) begin
            chk("R9 cmd", cmd_q, model[0]);
            chk("R9 ctl", ctl_q, model[1]);
            chk("R2 hi", hi_q, model[2]);
            chk("R2 lo", lo_q, model[3]);
            chk("R9 idle pull", sda_pull, 1'b0);
        end
        if (rst_n && sync_p) n_sync++;
        if (rst_n && clr_p)  n_clr++;
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic b_start(); m_sda = 1; wq(); scl = 1; wq(); m_sda = 0; wq(); scl = 0; wq(); endtask
    task automatic b_stop(); m_sda = 0; wq(); scl = 1; wq(); m_sda = 1; wq();
        repeat (8) @(negedge clk); busy = 0; endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
        end
        m_sda = 1; wq(); scl = 1; wq(); ack = !sda_line; wq(); scl = 0; wq();
    endtask

    task automatic rx_byte(input logic nak, output logic [7:0] d);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1; wq(); d[i] = sda_line; wq(); scl = 0;
        end
        wq(); m_sda = nak; wq(); scl = 1; wq(); wq(); scl = 0; wq(); m_sda = 1;
    endtask

    task automatic note_ptr(input logic [7:0] p);
        if (p[7]) e_sync++;
        if (p[6]) e_clr++;
    endtask

    task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, input string req);
        logic a0, a1, a2;
        busy = 1;
        b_start(); tx_byte(8'h88, a0); tx_byte(p, a1); note_ptr(p); tx_byte(d, a2);
        if (p[2:0] < 3'd4) model[p[1:0]] = d;
        b_stop();
        chk({req, " R1 addr ack"}, a0, 1'b1);
        chk({req, " ptr ack"}, a1, 1'b1);
        chk({req, " data ack"}, a2, 1'b1);
    endtask

    task automatic rd_reg(input logic [7:0] p, output logic [7:0] d);
        logic a0, a1, a2;
        busy = 1;
        b_start(); tx_byte(8'h88, a0); tx_byte(p, a1); note_ptr(p);
        b_start(); tx_byte(8'h89, a2); rx_byte(1'b1, d);
        b_stop();
        chk("R7 addr ack", {a0, a1, a2}, 3'b111);
    endtask

    initial begin
        logic [7:0] d;
        logic a;
        model[0] = 8'h00; model[1] = 8'h00; model[2] = 8'hFF; model[3] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset cmd", cmd_q, 8'h00);
        chk("R2 reset hi", hi_q, 8'hFF);
        chk("R9 reset pull", sda_pull, 1'b0);
        busy = 0;
        repeat (20) @(negedge clk);

        wr_reg(8'h00, 8'hA5, "R2");
        chk("R2 cmd written", cmd_q, 8'hA5);
        wr_reg(8'h01, 8'h3C, "R2");
        wr_reg(8'h03, 8'h12, "R2");
        chk("R2 lo written", lo_q, 8'h12);
        wr_reg(8'h3A, 8'h77, "R4");
        chk("R4 bits 5:3 ignored", hi_q, 8'h77);
        wr_reg(8'h05, 8'h99, "R3");
        chk("R3 ro write", {cmd_q, ctl_q, hi_q, lo_q}, 32'hA53C7712);

        rd_reg(8'h01, d);
        chk("R7 read ctl", d, 8'h3C);
        rd_reg(8'h02, d);
        chk("R7 read hi", d, 8'h77);

        // Non-matching address, then bytes that must be ignored (R1).
        busy = 1;
        b_start(); tx_byte(8'h90, a);
        chk("R1 wrong addr nak", a, 1'b0);
        tx_byte(8'h00, a); tx_byte(8'h55, a);
        chk("R1 ignored byte nak", a, 1'b0);
        b_stop();
        chk("R1 regs untouched", cmd_q, 8'hA5);

        // Second data byte in one write (R10).
        busy = 1;
        b_start(); tx_byte(8'h88, a); tx_byte(8'h03, a); tx_byte(8'h21, a);
        model[3] = 8'h21;
        tx_byte(8'h66, a);
        chk("R10 second byte nak", a, 1'b0);
        b_stop();
        chk("R10 lo holds first", lo_q, 8'h21);

        // Command strobes (R5, R6).
        wr_reg(8'h80, 8'hA5, "R5");
        chk("R5 sync count", n_sync, e_sync);
        wr_reg(8'h41, 8'h3C, "R6");
        chk("R6 clear count", n_clr, e_clr);
        wr_reg(8'hC3, 8'h21, "R5R6");
        chk("R5 sync both", n_sync, 2);
        chk("R6 clear both", n_clr, 2);

        // Upper-byte freeze (R8).
        sensor_v = 16'h1234; timer_v = 16'h5678;
        rd_reg(8'h04, d);
        chk("R8 sensor lsb", d, 8'h34);
        sensor_v = 16'hABCD;
        rd_reg(8'h05, d);
        chk("R8 sensor msb frozen", d, 8'h12);
        rd_reg(8'h06, d);
        chk("R8 timer lsb", d, 8'h78);
        timer_v = 16'h0000;
        rd_reg(8'h07, d);
        chk("R8 timer msb frozen", d, 8'h56);
        rd_reg(8'h05, d);
        chk("R8 msb still frozen", d, 8'h12);
        rd_reg(8'hF8, d);
        chk("R4 R7 read cmd via 0xF8", d, 8'hA5);
        chk("R5 final sync", n_sync, e_sync);
        chk("R6 final clear", n_clr, e_clr);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule